// File: doc/BRIEF.md
# Parallel Flash Identification Probe

This block sits on the host side of a byte-wide asynchronous parallel memory bus. It finds out what kind of memory is attached. When the host pulses `start`, the block first waits for the memory to go quiet. It then runs a non-destructive write test to see whether the memory is plain writable RAM. If it is not, it sends the three-write identification command sequence and reads back the manufacturer and device bytes.

The two identification bytes are accepted only if two things hold. Both bytes must read the same a second time at an address that is 0x100 higher. Each byte must also contain an odd number of one bits. When the bytes pass, the memory is a flash device, and the block writes the read-mode command before it finishes. When they fail, the memory is reported as read-only.

The result is a two-bit type code, the two ID bytes and a valid flag. All four are loaded together with a one-cycle `done` pulse. Every bus access holds its strobe for a parameterised number of clock cycles. The recovery wait inside the RAM test comes from a parameterised cycle counter; its default of 25000 cycles gives 100 µs at 250 MHz.

Top module: `flash_id_probe`

## Requirements
- R1: After `start`, the block reads address 0 again and again. It stops at the first read that equals the read before it, or after SETTLE_MAX reads in total, whichever comes first. In both cases it goes on to the RAM test.
- R2: RAM test, step one. The block reads address 0x555, writes that same byte back to 0x555, then writes 0xF0 to 0x555 and reads 0x555 again.
- R3: RAM test, step two. If that readback differs from the original byte, the block waits at least DELAY_CYC cycles and writes the original byte back. If 0x555 then reads as the original, it finishes with type code 1 (RAM) and `id_valid` low. The memory keeps its original content.
- R4: If 0x555 still differs after the restore, the block writes 0xF0 to 0x555 a second time and then goes on to the identification query.
- R5: The identification query is exactly three writes in this order: 0xAA to 0x555, 0x55 to 0x2AA, and 0x90 to 0x555. After them come reads of addresses 0, 1, 0x100 and 0x101, in that order.
- R6: The ID is rejected if the byte at 0 differs from the byte at 0x100, or if the byte at 1 differs from the byte at 0x101.
- R7: The ID is rejected if either byte has an even number of one bits.
- R8: A rejected ID ends the probe with type code 3 (ROM), `id_valid` low and both ID outputs at zero. No further bus write follows.
- R9: An accepted ID ends the probe with type code 2 (flash), the manufacturer byte from address 0, the device byte from address 1 and `id_valid` high. Before `done`, the block writes 0xF0 to 0x555 to put the device back in read mode.
- R10: `done` is high for exactly one cycle. The result outputs change only in the cycle where `done` is high, and `id_valid` is never high unless the type code is 2.
- R11: The block ignores `start` while a probe is running, so one probe gives exactly one `done`.
- R12: Each bus access holds its strobe for exactly ACC_CYC cycles. Address and write data stay stable while a strobe is high, and the read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a probe when the block is idle |
| done | output | 1 | One-cycle pulse when the results are loaded |
| mem_addr | output | ADDR_W | Memory bus address |
| mem_wdata | output | 8 | Memory bus write byte |
| mem_rdata | input | 8 | Memory bus read byte |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_type | output | 2 | 0 none, 1 RAM, 2 flash, 3 ROM |
| mfr_id | output | 8 | Manufacturer byte (flash only) |
| dev_id | output | 8 | Device byte (flash only) |
| id_valid | output | 1 | High when the ID bytes are valid |

## Verification
The bench attaches behavioural models of a RAM, a command-driven flash, a ROM and a location that only holds 0xF0, and checks the exact order of writes and reads for each. It goes after the following corner cases:
- The flash model is given even-parity ID bytes and, in a second run, a broken mirror at 0x100. A design that skipped either check would report flash instead of ROM.
- The stuck location exercises the second 0xF0 write. A design that dropped it would issue only one reset before the unlock writes.
- Address 0 is made to change on every read. A settle loop without its read limit would hang, and a loop with an off-by-one limit would show a read count other than SETTLE_MAX.
- A second `start` pulse in the middle of a probe checks that no second run starts.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_RAM   = 2'd1,
        KIND_FLASH = 2'd2,
        KIND_ROM   = 2'd3
    } mem_kind_e;

    typedef enum logic [4:0] {
        S_IDLE, S_SETTLE, S_RAM_RD, S_RAM_WB, S_RAM_F0, S_RAM_CHK,
        S_RAM_WAIT, S_RAM_RST, S_RAM_VER, S_RAM_F0B,
        S_UL1, S_UL2, S_UL3, S_ID0, S_ID1, S_ID2, S_ID3,
        S_EXIT, S_FIN
    } probe_state_e;

    localparam logic [7:0] CMD_READ_MODE = 8'hF0;
    localparam logic [7:0] CMD_UNLOCK_A  = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B  = 8'h55;
    localparam logic [7:0] CMD_ID_QUERY  = 8'h90;

    localparam logic [11:0] ADR_CMD_HI  = 12'h555;
    localparam logic [11:0] ADR_CMD_LO  = 12'h2AA;
    localparam logic [11:0] ADR_MIRROR  = 12'h100;

endpackage

// File: rtl/probe_bus_seq.sv
// Runs one bus access at a time. The strobe is held for ACC_CYC cycles,
// and ack marks the final cycle, in which the read data is valid.
module probe_bus_seq #(
    parameter int ADDR_W  = 12,
    parameter int ACC_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              ack,
    output logic [7:0]        rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic              mem_re
);
    localparam int CW = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;

    logic              busy_q, busy_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic              wr_q, wr_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [7:0]        wdata_q, wdata_d;
    logic              last;

    always_comb begin
        last    = busy_q && (cnt_q == CW'(ACC_CYC - 1));
        busy_d  = busy_q;
        cnt_d   = cnt_q;
        wr_d    = wr_q;
        addr_d  = addr_q;
        wdata_d = wdata_q;
        if (!busy_q && req) begin
            busy_d  = 1'b1;
            cnt_d   = '0;
            wr_d    = wr;
            addr_d  = addr;
            wdata_d = wdata;
        end else if (busy_q) begin
            if (last) busy_d = 1'b0;
            else      cnt_d  = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            busy_q  <= busy_d;
            cnt_q   <= cnt_d;
            wr_q    <= wr_d;
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
        end
    end

    assign ack       = last;
    assign rdata     = mem_rdata;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign mem_we    = busy_q && wr_q;
    assign mem_re    = busy_q && !wr_q;
endmodule

// File: rtl/probe_delay.sv
// One-shot wait. After go, expire goes high for one cycle, DELAY_CYC cycles later.
module probe_delay #(
    parameter int DELAY_CYC = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic expire
);
    localparam int CW = $clog2(DELAY_CYC + 1);

    logic          run_q, run_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        expire = run_q && (cnt_q == '0);
        run_d  = run_q;
        cnt_d  = cnt_q;
        if (go) begin
            run_d = 1'b1;
            cnt_d = CW'(DELAY_CYC - 1);
        end else if (expire) begin
            run_d = 1'b0;
        end else if (run_q) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            run_q <= run_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/probe_id_check.sv
// Decides whether the two ID bytes are plausible: each must match its
// mirror copy and have odd parity.
module probe_id_check (
    input  logic [7:0] lo_byte,
    input  logic [7:0] hi_byte,
    input  logic [7:0] lo_mirror,
    input  logic [7:0] hi_mirror,
    output logic       id_ok
);
    logic mirror_ok;
    logic parity_ok;

    always_comb begin
        mirror_ok = (lo_byte == lo_mirror) && (hi_byte == hi_mirror);
        parity_ok = (^lo_byte) && (^hi_byte);
        id_ok     = mirror_ok && parity_ok;
    end
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
    import flash_probe_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int ACC_CYC    = 3,
    parameter int SETTLE_MAX = 10000,
    parameter int DELAY_CYC  = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [1:0]        mem_type,
    output logic [7:0]        mfr_id,
    output logic [7:0]        dev_id,
    output logic              id_valid
);
    localparam int SW = $clog2(SETTLE_MAX + 1);
    localparam logic [ADDR_W-1:0] A_ZERO = '0;
    localparam logic [ADDR_W-1:0] A_ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(ADR_CMD_HI);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(ADR_CMD_LO);
    localparam logic [ADDR_W-1:0] A_M0   = ADDR_W'(ADR_MIRROR);
    localparam logic [ADDR_W-1:0] A_M1   = ADDR_W'(ADR_MIRROR + 12'h1);

    typedef struct packed {
        probe_state_e state;
        logic [SW-1:0] nreads;
        logic [7:0]    prev;
        logic [7:0]    orig;
        logic [7:0]    id0;
        logic [7:0]    id1;
        logic [7:0]    id2;
        mem_kind_e     pend;
        mem_kind_e     kind;
        logic [7:0]    mfr;
        logic [7:0]    dev;
        logic          valid;
        logic          done;
    } probe_regs_t;

    probe_regs_t q, d;

    logic              bus_req, bus_wr, bus_ack;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata, bus_rdata;
    logic              tmr_go, tmr_exp, id_ok;

    probe_bus_seq #(.ADDR_W(ADDR_W), .ACC_CYC(ACC_CYC)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .req(bus_req), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .ack(bus_ack), .rdata(bus_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_re(mem_re)
    );

    probe_delay #(.DELAY_CYC(DELAY_CYC)) u_delay (
        .clk(clk), .rst_n(rst_n), .go(tmr_go), .expire(tmr_exp)
    );

    probe_id_check u_idchk (
        .lo_byte(q.id0), .hi_byte(q.id1),
        .lo_mirror(q.id2), .hi_mirror(bus_rdata),
        .id_ok(id_ok)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        bus_req   = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = A_ZERO;
        bus_wdata = '0;
        tmr_go    = 1'b0;
        unique case (q.state)
            S_IDLE: begin
                if (start) begin
                    d.state  = S_SETTLE;
                    d.nreads = '0;
                end
            end
            S_SETTLE: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    if ((q.nreads != '0 && bus_rdata == q.prev) ||
                        (q.nreads == SW'(SETTLE_MAX - 1))) begin
                        d.state = S_RAM_RD;
                    end else begin
                        d.nreads = q.nreads + 1'b1;
                        d.prev   = bus_rdata;
                    end
                end
            end
            S_RAM_RD: begin
                bus_req  = 1'b1;
                bus_addr = A_HI;
                if (bus_ack) begin
                    d.orig  = bus_rdata;
                    d.state = S_RAM_WB;
                end
            end
            S_RAM_WB: begin
                bus_req = 1'b1; bus_wr = 1'b1; bus_addr = A_HI; bus_wdata = q.orig;
                if (bus_ack) d.state = S_RAM_F0;
            end
            S_RAM_F0: begin
                bus_req = 1'b1; bus_wr = 1'b1; bus_addr = A_HI; bus_wdata = CMD_READ_MODE;
                if (bus_ack) d.state = S_RAM_CHK;
            end
            S_RAM_CHK: begin
                bus_req  = 1'b1;
                bus_addr = A_HI;
                if (bus_ack) begin
                    if (bus_rdata != q.orig) begin
                        tmr_go  = 1'b1;
                        d.state = S_RAM_WAIT;
                    end else begin
                        d.state = S_UL1;
                    end
                end
            end
            S_RAM_WAIT: begin
                if (tmr_exp) d.state = S_RAM_RST;
            end
            S_RAM_RST: begin
                bus_req = 1'b1; bus_wr = 1'b1; bus_addr = A_HI; bus_wdata = q.orig;
                if (bus_ack) d.state = S_RAM_VER;
            end
            S_RAM_VER: begin
                bus_req  = 1'b1;
                bus_addr = A_HI;
                if (bus_ack) begin
                    if (bus_rdata == q.orig) begin
                        d.pend  = KIND_RAM;
                        d.state = S_FIN;
                    end else begin
                        d.state = S_RAM_F0B;
                    end
                end
            end
            S_RAM_F0B: begin
                bus_req = 1'b1; bus_wr = 1'b1; bus_addr = A_HI; bus_wdata = CMD_READ_MODE;
                if (bus_ack) d.state = S_UL1;
            end
            S_UL1: begin
                bus_req = 1'b1; bus_wr = 1'b1; bus_addr = A_HI; bus_wdata = CMD_UNLOCK_A;
                if (bus_ack) d.state = S_UL2;
            end
            S_UL2: begin
                bus_req = 1'b1; bus_wr = 1'b1; bus_addr = A_LO; bus_wdata = CMD_UNLOCK_B;
                if (bus_ack) d.state = S_UL3;
            end
            S_UL3: begin
                bus_req = 1'b1; bus_wr = 1'b1; bus_addr = A_HI; bus_wdata = CMD_ID_QUERY;
                if (bus_ack) d.state = S_ID0;
            end
            S_ID0: begin
                bus_req = 1'b1; bus_addr = A_ZERO;
                if (bus_ack) begin d.id0 = bus_rdata; d.state = S_ID1; end
            end
            S_ID1: begin
                bus_req = 1'b1; bus_addr = A_ONE;
                if (bus_ack) begin d.id1 = bus_rdata; d.state = S_ID2; end
            end
            S_ID2: begin
                bus_req = 1'b1; bus_addr = A_M0;
                if (bus_ack) begin d.id2 = bus_rdata; d.state = S_ID3; end
            end
            S_ID3: begin
                bus_req = 1'b1; bus_addr = A_M1;
                if (bus_ack) begin
                    if (id_ok) begin
                        d.pend  = KIND_FLASH;
                        d.state = S_EXIT;
                    end else begin
                        d.pend  = KIND_ROM;
                        d.state = S_FIN;
                    end
                end
            end
            S_EXIT: begin
                bus_req = 1'b1; bus_wr = 1'b1; bus_addr = A_HI; bus_wdata = CMD_READ_MODE;
                if (bus_ack) d.state = S_FIN;
            end
            S_FIN: begin
                d.done  = 1'b1;
                d.kind  = q.pend;
                d.valid = (q.pend == KIND_FLASH);
                d.mfr   = (q.pend == KIND_FLASH) ? q.id0 : 8'h00;
                d.dev   = (q.pend == KIND_FLASH) ? q.id1 : 8'h00;
                d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= S_IDLE;
            q.nreads <= '0;
            q.prev   <= '0;
            q.orig   <= '0;
            q.id0    <= '0;
            q.id1    <= '0;
            q.id2    <= '0;
            q.pend   <= KIND_NONE;
            q.kind   <= KIND_NONE;
            q.mfr    <= '0;
            q.dev    <= '0;
            q.valid  <= 1'b0;
            q.done   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign done     = q.done;
    assign mem_type = q.kind;
    assign mfr_id   = q.mfr;
    assign dev_id   = q.dev;
    assign id_valid = q.valid;
endmodule

// File: rtl/flash_id_probe_chk.sv
module flash_id_probe_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_we,
    input logic              mem_re,
    input logic [1:0]        mem_type,
    input logic [7:0]        mfr_id,
    input logic [7:0]        dev_id,
    input logic              id_valid
);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(mem_type) && $stable(mfr_id) && $stable(dev_id) && $stable(id_valid)));

    // R10
    valid_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> (mem_type == 2'd2));

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R12
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && $past(mem_we || mem_re)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

    // R9
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_we && !mem_re));
endmodule

bind flash_id_probe flash_id_probe_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/flash_id_probe_bench.sv
`timescale 1ns/1ps
module flash_id_probe_bench;
    localparam int AW = 12;
    localparam int ACC = 3;
    localparam int SMAX = 16;
    localparam int DLY = 40;
    localparam logic [AW-1:0] A555 = 12'h555;

    localparam int K_RAM = 0, K_FLASH = 1, K_ROM = 2, K_STICK = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic done;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic mem_we, mem_re;
    logic [1:0] mem_type;
    logic [7:0] mfr_id, dev_id;
    logic id_valid;

    always #2 clk = ~clk;

    flash_id_probe #(.ADDR_W(AW), .ACC_CYC(ACC), .SETTLE_MAX(SMAX), .DELAY_CYC(DLY)) u_flash_id_probe (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_type(mem_type),
        .mfr_id(mfr_id), .dev_id(dev_id), .id_valid(id_valid)
    );

    // ---------------- memory model ----------------
    int kind = K_ROM;
    logic [7:0] m_mfr = 8'h01, m_dev = 8'hAD;
    bit bad_mirror = 0;
    int tog_lim = 0;
    bit clr = 0;

    logic [7:0] mem [0:4095];
    logic we_q = 0, re_q = 0;
    bit id_mode = 0;
    int step = 0;
    int tog_cnt = 0, rd0_pre = 0;
    bit seen555 = 0;
    int cyc = 0, we_len = 0, last_we_len = 0;
    int nwr = 0, nrd = 0;
    logic [AW-1:0] wr_a [0:63];
    logic [7:0]    wr_d [0:63];
    int            wr_t [0:63];
    logic [AW-1:0] rd_a [0:63];
    int done_cnt = 0;

    always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

    always_comb begin
        if (kind == K_FLASH && id_mode) begin
            if (mem_addr[7:0] == 8'h00)
                mem_rdata = (mem_addr[8] && bad_mirror) ? (m_mfr ^ 8'h01) : m_mfr;
            else if (mem_addr[7:0] == 8'h01)
                mem_rdata = m_dev;
            else
                mem_rdata = 8'h00;
        end else if (mem_addr == '0 && tog_cnt <= tog_lim && tog_cnt > 0) begin
            mem_rdata = tog_cnt[7:0];
        end else begin
            mem_rdata = mem[mem_addr];
        end
    end

    always @(posedge clk) begin
        we_q <= mem_we;
        re_q <= mem_re;
        cyc  <= cyc + 1;
        if (clr) begin
            for (int i = 0; i < 4096; i++) mem[i] <= 8'(i) ^ {4'(i >> 8), 4'h0};
            mem[12'h555] <= 8'h3C;
            id_mode <= 0; step <= 0; tog_cnt <= 0; rd0_pre <= 0; seen555 <= 0;
            nwr <= 0; nrd <= 0; we_len <= 0; last_we_len <= 0;
        end else begin
            if (mem_we && !we_q) we_len <= 1;
            else if (mem_we) we_len <= we_len + 1;
            if (!mem_we && we_q) last_we_len <= we_len;
            if (mem_we && !we_q) begin
                if (nwr < 64) begin
                    wr_a[nwr] <= mem_addr; wr_d[nwr] <= mem_wdata; wr_t[nwr] <= cyc;
                end
                nwr <= nwr + 1;
                case (kind)
                    K_RAM: mem[mem_addr] <= mem_wdata;
                    K_STICK: if (mem_addr == A555 && mem_wdata == 8'hF0) mem[mem_addr] <= 8'hF0;
                    K_FLASH: begin
                        if (mem_wdata == 8'hF0) begin id_mode <= 0; step <= 0; end
                        else if (mem_addr == A555 && mem_wdata == 8'hAA) step <= 1;
                        else if (step == 1 && mem_addr == 12'h2AA && mem_wdata == 8'h55) step <= 2;
                        else if (step == 2 && mem_addr == A555 && mem_wdata == 8'h90) begin
                            id_mode <= 1; step <= 0;
                        end else step <= 0;
                    end
                    default: ;
                endcase
            end
            if (mem_re && !re_q) begin
                if (nrd < 64) rd_a[nrd] <= mem_addr;
                nrd <= nrd + 1;
                if (mem_addr == '0) begin
                    tog_cnt <= tog_cnt + 1;
                    if (!seen555) rd0_pre <= rd0_pre + 1;
                end
                if (mem_addr == A555) seen555 <= 1;
            end
        end
    end

    // ---------------- checking ----------------
    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic setup(input int k);
        kind = k;
        bad_mirror = 0;
        tog_lim = 0;
        m_mfr = 8'h01;
        m_dev = 8'hAD;
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
    endtask

    task automatic run_probe();
        int base;
        base = done_cnt;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        for (int i = 0; i < 4000; i++) begin
            if (done_cnt != base) break;
            @(negedge clk);
        end
        check(done_cnt == base + 1, "R10 one done per probe", done_cnt - base, 1);
    endtask

    task automatic t_reset();
        check(mem_type == 2'd0, "R10 reset type", mem_type, 0);
        check(id_valid == 1'b0 && done == 1'b0, "R10 reset valid/done", {id_valid, done}, 0);
        check(!mem_we && !mem_re, "R12 reset strobes idle", {mem_we, mem_re}, 0);
    endtask

    task automatic t_flash();
        setup(K_FLASH);
        run_probe();
        check(mem_type == 2'd2, "R9 flash type", mem_type, 2);
        check(mfr_id == 8'h01 && dev_id == 8'hAD, "R9 id bytes", {mfr_id, dev_id}, 16'h01AD);
        check(id_valid == 1'b1, "R9 valid", id_valid, 1);
        check(nwr == 6, "R9 write count", nwr, 6);
        check(wr_a[2] == A555 && wr_d[2] == 8'hAA, "R5 unlock 1", {wr_a[2], wr_d[2]}, {A555, 8'hAA});
        check(wr_a[3] == 12'h2AA && wr_d[3] == 8'h55, "R5 unlock 2", {wr_a[3], wr_d[3]}, {12'h2AA, 8'h55});
        check(wr_a[4] == A555 && wr_d[4] == 8'h90, "R5 id query", {wr_a[4], wr_d[4]}, {A555, 8'h90});
        check(wr_a[5] == A555 && wr_d[5] == 8'hF0, "R9 exit write", {wr_a[5], wr_d[5]}, {A555, 8'hF0});
        check(id_mode == 0, "R9 device back in read mode", id_mode, 0);
        check(nrd == 8 && rd_a[4] == 12'h000 && rd_a[5] == 12'h001 &&
              rd_a[6] == 12'h100 && rd_a[7] == 12'h101, "R5 id read order",
              {rd_a[6], rd_a[7]}, {12'h100, 12'h101});
        check(rd_a[0] == 0 && rd_a[1] == 0 && rd_a[2] == A555 && rd_a[3] == A555, "R1 settle two reads",
              rd0_pre, 2);
        check(wr_a[0] == A555 && wr_d[0] == 8'h3C && wr_d[1] == 8'hF0, "R2 write-back then F0",
              {wr_d[0], wr_d[1]}, 16'h3CF0);
        check(last_we_len == ACC, "R12 strobe length", last_we_len, ACC);
    endtask

    task automatic t_ram();
        setup(K_RAM);
        run_probe();
        check(mem_type == 2'd1 && id_valid == 0, "R3 ram type", {mem_type, id_valid}, 2);
        check(nwr == 3 && wr_d[2] == 8'h3C, "R3 restore write", wr_d[2], 8'h3C);
        check(wr_t[2] - wr_t[1] >= DLY, "R3 restore wait", wr_t[2] - wr_t[1], DLY);
        check(mem[A555] == 8'h3C, "R3 content preserved", mem[A555], 8'h3C);
        check(nrd == 5, "R2 ram reads", nrd, 5);
    endtask

    task automatic t_rom();
        setup(K_ROM);
        run_probe();
        check(mem_type == 2'd3 && id_valid == 0, "R8 rom type", {mem_type, id_valid}, 3);
        check(mfr_id == 0 && dev_id == 0, "R8 ids zero", {mfr_id, dev_id}, 0);
        check(nwr == 5, "R8 no trailing write", nwr, 5);
    endtask

    task automatic t_parity();
        setup(K_FLASH);
        m_dev = 8'h03;
        run_probe();
        check(mem_type == 2'd3 && id_valid == 0, "R7 even parity rejected", mem_type, 3);
        setup(K_FLASH);
        m_mfr = 8'h07;
        m_dev = 8'h80;
        run_probe();
        check(mem_type == 2'd2 && mfr_id == 8'h07 && dev_id == 8'h80, "R7 odd parity accepted",
              {mem_type, mfr_id, dev_id}, {2'd2, 16'h0780});
    endtask

    task automatic t_mirror();
        setup(K_FLASH);
        bad_mirror = 1;
        run_probe();
        check(mem_type == 2'd3 && id_valid == 0, "R6 mirror mismatch rejected", mem_type, 3);
    endtask

    task automatic t_restore_fail();
        setup(K_STICK);
        run_probe();
        check(nwr == 7, "R4 write count", nwr, 7);
        check(wr_a[3] == A555 && wr_d[3] == 8'hF0, "R4 second F0", wr_d[3], 8'hF0);
        check(wr_d[4] == 8'hAA, "R4 query follows", wr_d[4], 8'hAA);
        check(mem_type == 2'd3, "R4 ends as rom", mem_type, 3);
    endtask

    task automatic t_settle();
        setup(K_ROM);
        tog_lim = 5;
        run_probe();
        check(rd0_pre == 7, "R1 settle after change", rd0_pre, 7);
        setup(K_ROM);
        tog_lim = 1000;
        run_probe();
        check(rd0_pre == SMAX, "R1 settle give-up limit", rd0_pre, SMAX);
    endtask

    task automatic t_start_ignored();
        int base, rds;
        setup(K_FLASH);
        base = done_cnt;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (20) @(negedge clk);
        start = 1;
        @(negedge clk); start = 0;
        repeat (600) @(negedge clk);
        check(done_cnt == base + 1, "R11 one done despite second start", done_cnt - base, 1);
        rds = nrd;
        check(rds == 8, "R11 no extra bus traffic", rds, 8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        setup(K_ROM);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_flash();
        t_ram();
        t_rom();
        t_parity();
        t_mirror();
        t_restore_fail();
        t_settle();
        t_start_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule